// File: doc/BRIEF.md
# Chained Peripheral DMA Channel

This block moves words between one peripheral and system memory, in both directions at once. The receive side takes words that the peripheral offers on a valid/ready handshake and writes them to memory. The transmit side reads words from memory and offers them to the peripheral on a second valid/ready handshake. Each side works through a current address and word count. A queued second address and count move into the current pair when it runs dry, so software can chain two buffers without a gap.

Software controls the channel through a small word-addressed register port. Separate write-one strobes turn each direction on and off, and a status word reads back both enable bits. Four flags come straight from the counters: an end flag for each direction when its current count is zero, and a buffer flag for each direction when both its current and its queued counts are zero. A write-one set register and a write-one clear register edit the mask over these flags. The interrupt line is high while any unmasked flag is set.

Top module: `dmac_channel`

Register map (word index on `reg_addr`): 0 receive current address, 1 receive current count, 2 receive queued address, 3 receive queued count, 4 to 7 the same four for transmit, 8 control (write-only, reads 0), 9 enable status, 10 flags, 11 mask set, 12 mask clear, 13 mask read-back. Flag and mask bit positions: bit 0 receive end, bit 1 receive full, bit 2 transmit end, bit 3 transmit empty. Control bits: bit 0 receive on, bit 1 receive off, bit 2 transmit on, bit 3 transmit off. Status bits: bit 0 receive enabled, bit 1 transmit enabled.

## Requirements
- R1: After reset all addresses and counts read 0, status reads 0, the mask reads 0, flags read 4'hF and `irq` is low.
- R2: A control write with bit 0 or bit 2 set enables receive or transmit respectively. Both directions may change in one write, and zero bits leave the enable state unchanged. Status bit 0 and bit 1 report the receive and transmit enable state.
- R3: When a single control write sets both the on bit and the off bit of one direction, that direction ends disabled.
- R4: While receive is enabled and its current count is nonzero, a word offered with `rx_valid` is accepted (`rx_ready` high) only in a cycle where `mw_gnt` is high. It is written to memory at the current receive address. After each word the address rises by the word size in bytes (4 by default) and the count falls by one.
- R5: While transmit is enabled and its current count is nonzero, the block reads memory at the current transmit address and presents that word on `tx_data` with `tx_valid`. On the `tx_ready` handshake the address rises by the word size and the count falls by one.
- R6: When a direction's current count is zero and its queued count is nonzero and no register is written in that cycle, the next clock edge copies the queued address and count into the current pair and the queued count reads 0. This also covers writing the queued count while the current count is already zero.
- R7: The flags follow the counts. They clear on the clock edge after a nonzero count is written, and each end flag rises on the edge where its current count reaches zero.
- R8: A write to mask-set ORs its low four bits into the mask, and a write to mask-clear removes them. `irq` is high exactly while some flag and its mask bit are both set.
- R9: A disabled direction issues no memory requests and no handshakes, and it keeps its address and count. When enabled again it resumes at the same address.
- R10: A direction whose current count is zero makes no transfer: `rx_ready` and `mw_req` stay low, and transmit does not fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | OR of all set and unmasked flags |
| rx_valid | input | 1 | Peripheral offers a received word |
| rx_data | input | DATA_W | Received word |
| rx_ready | output | 1 | Channel accepts the received word |
| tx_valid | output | 1 | Channel offers a word to transmit |
| tx_data | output | DATA_W | Word to transmit |
| tx_ready | input | 1 | Peripheral takes the offered word |
| mw_req | output | 1 | Memory write request |
| mw_addr | output | 32 | Memory write address |
| mw_data | output | DATA_W | Memory write data |
| mw_gnt | input | 1 | Memory accepts the write this cycle |
| mr_req | output | 1 | Memory read request |
| mr_addr | output | 32 | Memory read address |
| mr_gnt | input | 1 | Memory accepts the read request this cycle |
| mr_rvalid | input | 1 | Read data is valid |
| mr_rdata | input | DATA_W | Read data |

## Verification
A corrupted count or address shows up on the next handshake as a memory write to the wrong address or a transmitted word from the wrong place. The scoreboard catches it at that beat. A missed or early reload shows up as a chained stream that stalls, writes past the first buffer, or pulses the end interrupt a different number of times than once per drained buffer. A wrong enable or mask bit shows up within one cycle at `rx_ready`, `tx_valid`, `irq` or on the status and mask read-back.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int REG_AW = 4;
    localparam int REG_DW = 32;
    localparam int NFLAG  = 4;
    localparam int NDIR   = 2;

    localparam int DIR_RX = 0;
    localparam int DIR_TX = 1;

    // flag / mask bit positions
    localparam int FL_RX_END   = 0;
    localparam int FL_RX_FULL  = 1;
    localparam int FL_TX_END   = 2;
    localparam int FL_TX_EMPTY = 3;

    // control strobe bit positions
    localparam int CT_RX_ON  = 0;
    localparam int CT_RX_OFF = 1;
    localparam int CT_TX_ON  = 2;
    localparam int CT_TX_OFF = 3;

    typedef enum logic [REG_AW-1:0] {
        A_RX_CPTR = 4'd0,
        A_RX_CCNT = 4'd1,
        A_RX_NPTR = 4'd2,
        A_RX_NCNT = 4'd3,
        A_TX_CPTR = 4'd4,
        A_TX_CCNT = 4'd5,
        A_TX_NPTR = 4'd6,
        A_TX_NCNT = 4'd7,
        A_CTRL    = 4'd8,
        A_STAT    = 4'd9,
        A_FLAG    = 4'd10,
        A_MSET    = 4'd11,
        A_MCLR    = 4'd12,
        A_MASK    = 4'd13
    } reg_sel_e;

    typedef struct packed {
        logic cptr;
        logic ccnt;
        logic nptr;
        logic ncnt;
    } chain_we_t;

    typedef struct packed {
        logic [ADDR_W-1:0] cptr;
        logic [CNT_W-1:0]  ccnt;
        logic [ADDR_W-1:0] nptr;
        logic [CNT_W-1:0]  ncnt;
    } chain_st_t;

    typedef enum logic [1:0] {
        TXF_IDLE = 2'd0,
        TXF_WAIT = 2'd1,
        TXF_HOLD = 2'd2
    } txf_state_e;

    function automatic logic cur_empty(input chain_st_t s);
        return s.ccnt == '0;
    endfunction

    function automatic logic both_empty(input chain_st_t s);
        return (s.ccnt == '0) && (s.ncnt == '0);
    endfunction

    function automatic logic [NFLAG-1:0] flags_of(input chain_st_t rx, input chain_st_t tx);
        logic [NFLAG-1:0] f;
        f              = '0;
        f[FL_RX_END]   = cur_empty(rx);
        f[FL_RX_FULL]  = both_empty(rx);
        f[FL_TX_END]   = cur_empty(tx);
        f[FL_TX_EMPTY] = both_empty(tx);
        return f;
    endfunction

endpackage

// File: rtl/dmac_chain.sv
module dmac_chain
    import dmac_pkg::*;
#(
    parameter int STEP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  chain_we_t         we,
    input  logic [REG_DW-1:0] wdata,
    input  logic              step,
    output chain_st_t         st
);

    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

    chain_st_t q;
    chain_st_t d;
    logic      any_we;
    logic      reload;
    logic      adv;

    always_comb begin
        any_we = we.cptr | we.ccnt | we.nptr | we.ncnt;
        adv    = step && (q.ccnt != '0);
        reload = (q.ccnt == '0) && (q.ncnt != '0) && !any_we;
        d      = q;

        if (we.cptr)
            d.cptr = wdata[ADDR_W-1:0];
        else if (adv)
            d.cptr = q.cptr + STEP_A;

        if (we.ccnt)
            d.ccnt = wdata[CNT_W-1:0];
        else if (adv)
            d.ccnt = q.ccnt - 1'b1;

        if (we.nptr)
            d.nptr = wdata[ADDR_W-1:0];
        if (we.ncnt)
            d.ncnt = wdata[CNT_W-1:0];

        if (reload) begin
            d.cptr = q.nptr;
            d.ccnt = q.ncnt;
            d.ncnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end

    assign st = q;

endmodule

// File: rtl/dmac_rxpath.sv
module dmac_rxpath
    import dmac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              en,
    input  logic              has_work,
    input  logic [ADDR_W-1:0] cptr,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              mw_req,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [DATA_W-1:0] mw_data,
    input  logic              mw_gnt,
    output logic              step
);

    logic live;

    always_comb begin
        live     = en && has_work;
        mw_req   = live && rx_valid;
        rx_ready = live && mw_gnt;
        mw_addr  = cptr;
        mw_data  = rx_data;
        step     = mw_req && mw_gnt;
    end

endmodule

// File: rtl/dmac_txfetch.sv
module dmac_txfetch
    import dmac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              has_work,
    input  logic [ADDR_W-1:0] cptr,
    output logic              mr_req,
    output logic [ADDR_W-1:0] mr_addr,
    input  logic              mr_gnt,
    input  logic              mr_rvalid,
    input  logic [DATA_W-1:0] mr_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              step
);

    txf_state_e        state_q, state_d;
    logic [DATA_W-1:0] buf_q, buf_d;

    always_comb begin
        state_d  = state_q;
        buf_d    = buf_q;
        mr_req   = 1'b0;
        tx_valid = 1'b0;
        step     = 1'b0;
        mr_addr  = cptr;
        unique case (state_q)
            TXF_IDLE: begin
                mr_req = en && has_work;
                if (mr_req && mr_gnt)
                    state_d = TXF_WAIT;
            end
            TXF_WAIT: begin
                if (mr_rvalid) begin
                    buf_d   = mr_rdata;
                    state_d = TXF_HOLD;
                end
            end
            TXF_HOLD: begin
                tx_valid = en && has_work;
                if (tx_valid && tx_ready) begin
                    step    = 1'b1;
                    state_d = TXF_IDLE;
                end
            end
            default: state_d = TXF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TXF_IDLE;
            buf_q   <= '0;
        end else begin
            state_q <= state_d;
            buf_q   <= buf_d;
        end
    end

    assign tx_data = buf_q;

endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  chain_st_t         rx_st,
    input  chain_st_t         tx_st,
    output chain_we_t         rx_we,
    output chain_we_t         tx_we,
    output logic              rx_en,
    output logic              tx_en,
    output logic [NFLAG-1:0]  mask,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq
);

    reg_sel_e         sel;
    logic             wr_ctrl;
    logic             wr_mset;
    logic             wr_mclr;
    logic [NFLAG-1:0] flags;

    assign sel = reg_sel_e'(reg_addr);

    always_comb begin
        rx_we = '0;
        tx_we = '0;
        if (reg_wr) begin
            case (sel)
                A_RX_CPTR: rx_we.cptr = 1'b1;
                A_RX_CCNT: rx_we.ccnt = 1'b1;
                A_RX_NPTR: rx_we.nptr = 1'b1;
                A_RX_NCNT: rx_we.ncnt = 1'b1;
                A_TX_CPTR: tx_we.cptr = 1'b1;
                A_TX_CCNT: tx_we.ccnt = 1'b1;
                A_TX_NPTR: tx_we.nptr = 1'b1;
                A_TX_NCNT: tx_we.ncnt = 1'b1;
                default: ;
            endcase
        end
    end

    assign wr_ctrl = reg_wr && (sel == A_CTRL);
    assign wr_mset = reg_wr && (sel == A_MSET);
    assign wr_mclr = reg_wr && (sel == A_MCLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en <= 1'b0;
            tx_en <= 1'b0;
            mask  <= '0;
        end else begin
            if (wr_ctrl) begin
                rx_en <= (rx_en | reg_wdata[CT_RX_ON]) & ~reg_wdata[CT_RX_OFF];
                tx_en <= (tx_en | reg_wdata[CT_TX_ON]) & ~reg_wdata[CT_TX_OFF];
            end
            if (wr_mset)
                mask <= mask | reg_wdata[NFLAG-1:0];
            else if (wr_mclr)
                mask <= mask & ~reg_wdata[NFLAG-1:0];
        end
    end

    always_comb begin
        flags = flags_of(rx_st, tx_st);
        irq   = |(flags & mask);
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            A_RX_CPTR: reg_rdata = REG_DW'(rx_st.cptr);
            A_RX_CCNT: reg_rdata = REG_DW'(rx_st.ccnt);
            A_RX_NPTR: reg_rdata = REG_DW'(rx_st.nptr);
            A_RX_NCNT: reg_rdata = REG_DW'(rx_st.ncnt);
            A_TX_CPTR: reg_rdata = REG_DW'(tx_st.cptr);
            A_TX_CCNT: reg_rdata = REG_DW'(tx_st.ccnt);
            A_TX_NPTR: reg_rdata = REG_DW'(tx_st.nptr);
            A_TX_NCNT: reg_rdata = REG_DW'(tx_st.ncnt);
            A_STAT:    reg_rdata = REG_DW'({tx_en, rx_en});
            A_FLAG:    reg_rdata = REG_DW'(flags);
            A_MASK:    reg_rdata = REG_DW'(mask);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int DATA_W         = 32,
    parameter int BYTES_PER_WORD = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              mw_req,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [DATA_W-1:0] mw_data,
    input  logic              mw_gnt,
    output logic              mr_req,
    output logic [ADDR_W-1:0] mr_addr,
    input  logic              mr_gnt,
    input  logic              mr_rvalid,
    input  logic [DATA_W-1:0] mr_rdata
);

    chain_we_t        ch_we   [NDIR];
    chain_st_t        ch_st   [NDIR];
    logic             ch_step [NDIR];
    logic             rx_en;
    logic             tx_en;
    logic [NFLAG-1:0] mask;
    chain_st_t        rx_st;
    chain_st_t        tx_st;

    assign rx_st = ch_st[DIR_RX];
    assign tx_st = ch_st[DIR_TX];

    dmac_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .rx_st     (rx_st),
        .tx_st     (tx_st),
        .rx_we     (ch_we[DIR_RX]),
        .tx_we     (ch_we[DIR_TX]),
        .rx_en     (rx_en),
        .tx_en     (tx_en),
        .mask      (mask),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    for (genvar g = 0; g < NDIR; g++) begin : g_chain
        dmac_chain #(
            .STEP (BYTES_PER_WORD)
        ) u_chain (
            .clk   (clk),
            .rst   (rst),
            .we    (ch_we[g]),
            .wdata (reg_wdata),
            .step  (ch_step[g]),
            .st    (ch_st[g])
        );
    end

    dmac_rxpath #(
        .DATA_W (DATA_W)
    ) u_rx (
        .en       (rx_en),
        .has_work (!cur_empty(rx_st)),
        .cptr     (rx_st.cptr),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .mw_req   (mw_req),
        .mw_addr  (mw_addr),
        .mw_data  (mw_data),
        .mw_gnt   (mw_gnt),
        .step     (ch_step[DIR_RX])
    );

    dmac_txfetch #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .en        (tx_en),
        .has_work  (!cur_empty(tx_st)),
        .cptr      (tx_st.cptr),
        .mr_req    (mr_req),
        .mr_addr   (mr_addr),
        .mr_gnt    (mr_gnt),
        .mr_rvalid (mr_rvalid),
        .mr_rdata  (mr_rdata),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .step      (ch_step[DIR_TX])
    );

endmodule

// File: rtl/dmac_channel_chk.sv
module dmac_channel_chk
    import dmac_pkg::*;
#(
    parameter int STEP = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic              rx_en,
    input logic              tx_en,
    input chain_st_t         rx_st,
    input chain_st_t         tx_st,
    input logic              mw_req,
    input logic              mw_gnt,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [NFLAG-1:0]  mask,
    input logic              irq
);

    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

    logic ctrl_wr;
    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);

    assert_rx_on_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && reg_wdata[CT_RX_ON] && !reg_wdata[CT_RX_OFF] |=> rx_en);

    assert_off_wins_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && reg_wdata[CT_RX_OFF] |=> !rx_en);

    assert_rx_advance_R4: assert property (@(posedge clk) disable iff (rst)
        mw_req && mw_gnt && !reg_wr |=>
            (rx_st.ccnt == $past(rx_st.ccnt) - 1'b1) && (rx_st.cptr == $past(rx_st.cptr) + STEP_A));

    assert_tx_offer_R5: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> tx_en && (tx_st.ccnt != '0));

    assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_st.ccnt == '0) && (rx_st.ncnt != '0) && !reg_wr |=>
            (rx_st.ccnt == $past(rx_st.ncnt)) && (rx_st.cptr == $past(rx_st.nptr)) && (rx_st.ncnt == '0));

    assert_no_irq_unmasked_R8: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);

    assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        !rx_en && (rx_st.ccnt != '0) && !reg_wr |=> $stable(rx_st.ccnt) && $stable(rx_st.cptr));

    assert_idle_when_empty_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_st.ccnt == '0) |-> !rx_ready && !mw_req);

endmodule

bind dmac_channel dmac_channel_chk #(
    .STEP (BYTES_PER_WORD)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rx_en     (rx_en),
    .tx_en     (tx_en),
    .rx_st     (rx_st),
    .tx_st     (tx_st),
    .mw_req    (mw_req),
    .mw_gnt    (mw_gnt),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .mask      (mask),
    .irq       (irq)
);

// File: tb/test_dmac_channel.sv
module test_dmac_channel;
    import dmac_pkg::*;

    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [REG_AW-1:0] reg_addr = '0;
    logic [REG_DW-1:0] reg_wdata = '0;
    logic [REG_DW-1:0] reg_rdata;
    logic              irq;
    logic              rx_valid = 1'b0;
    logic [DATA_W-1:0] rx_data = '0;
    logic              rx_ready;
    logic              tx_valid;
    logic [DATA_W-1:0] tx_data;
    logic              tx_ready = 1'b1;
    logic              mw_req;
    logic [ADDR_W-1:0] mw_addr;
    logic [DATA_W-1:0] mw_data;
    logic              mw_gnt = 1'b1;
    logic              mr_req;
    logic [ADDR_W-1:0] mr_addr;
    logic              mr_gnt = 1'b1;
    logic              mr_rvalid = 1'b0;
    logic [DATA_W-1:0] mr_rdata = '0;

    always #10 clk = ~clk;

    dmac_channel i_dmac_channel (.*);

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    bit  stall_pat = 0;
    bit  count_irq = 0;
    bit  irq_q = 0;
    int  irq_rises = 0;
    int  cyc = 0;
    logic [63:0] exp_mw[$];
    logic [31:0] exp_tx[$];

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string req);
        reg_addr = a; #1;
        chk(reg_rdata == e, req, 64'(reg_rdata), 64'(e));
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_rx(input logic [31:0] a, input logic [31:0] d);
        exp_mw.push_back({a, d});
        rx_valid = 1'b1; rx_data = d;
        do @(negedge clk); while (!rx_ready);
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    // stall patterns and cycle counter
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        mw_gnt   = stall_pat ? ((cyc % 4) != 2) : 1'b1;
        tx_ready = stall_pat ? ((cyc % 3) != 1) : 1'b1;
    end

    // memory read responder: one cycle of latency after the accepted request
    initial begin
        forever begin
            logic p;
            logic [31:0] a;
            @(negedge clk);
            p = mr_req && mr_gnt && !rst;
            a = mr_addr;
            @(posedge clk); #1;
            mr_rvalid = p;
            mr_rdata  = p ? mem_word(a) : '0;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (mw_req && mw_gnt) begin
                if (exp_mw.size() == 0)
                    chk(1'b0, "R4 unexpected memory write", {mw_addr, mw_data}, 64'd0);
                else begin
                    logic [63:0] e;
                    e = exp_mw.pop_front();
                    chk({mw_addr, mw_data} == e, "R4/R6 receive write", {mw_addr, mw_data}, e);
                end
            end
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0)
                    chk(1'b0, "R5 unexpected transmit word", 64'(tx_data), 64'd0);
                else begin
                    logic [31:0] e;
                    e = exp_tx.pop_front();
                    chk(tx_data == e, "R5/R6 transmit word", 64'(tx_data), 64'(e));
                end
            end
            if (count_irq && irq && !irq_q)
                irq_rises++;
            irq_q = irq;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        for (int a = 0; a < 8; a++) rd_chk(4'(a), 32'd0, "R1 pointer/count reset");
        rd_chk(A_STAT, 32'd0, "R1 status reset");
        rd_chk(A_FLAG, 32'hF, "R1 flags reset");
        rd_chk(A_MASK, 32'd0, "R1 mask reset");
        chk(irq == 1'b0, "R1 irq reset", 64'(irq), 64'd0);

        // R2 / R3 control strobes
        wr(A_CTRL, 32'h5);
        rd_chk(A_STAT, 32'h3, "R2 both on in one write");
        wr(A_CTRL, 32'h0);
        rd_chk(A_STAT, 32'h3, "R2 zero write no effect");
        wr(A_CTRL, 32'h2);
        rd_chk(A_STAT, 32'h2, "R2 receive off only");
        wr(A_CTRL, 32'hC);
        rd_chk(A_STAT, 32'h0, "R3 transmit on+off ends off");
        wr(A_CTRL, 32'h3);
        rd_chk(A_STAT, 32'h0, "R3 receive on+off ends off");

        // R4 / R6 / R7 / R8 chained receive with stalls
        wr(A_RX_CPTR, 32'h1000);
        wr(A_RX_CCNT, 32'd3);
        wr(A_RX_NPTR, 32'h2000);
        wr(A_RX_NCNT, 32'd2);
        rd_chk(A_FLAG, 32'hC, "R7 receive flags clear after count write");
        wr(A_MSET, 32'h1);
        chk(irq == 1'b0, "R8 masked end not set", 64'(irq), 64'd0);
        count_irq = 1'b1;
        stall_pat = 1'b1;
        wr(A_CTRL, 32'h1);
        for (int i = 0; i < 3; i++) send_rx(32'h1000 + 32'(4 * i), 32'hC0DE_0000 + 32'(i));
        for (int i = 0; i < 2; i++) send_rx(32'h2000 + 32'(4 * i), 32'hC0DE_0010 + 32'(i));
        idle(3);
        count_irq = 1'b0;
        stall_pat = 1'b0;
        chk(irq_rises == 2, "R6/R8 end interrupt once per drained buffer", 64'(irq_rises), 64'd2);
        rd_chk(A_RX_CPTR, 32'h2008, "R4 pointer after chained stream");
        rd_chk(A_RX_CCNT, 32'd0, "R6 current count drained");
        rd_chk(A_RX_NCNT, 32'd0, "R6 queued count consumed");
        rd_chk(A_FLAG, 32'hF, "R7 end and full flags set");

        // R8 mask set/clear
        chk(irq == 1'b1, "R8 irq from end flag", 64'(irq), 64'd1);
        wr(A_MSET, 32'h2);
        rd_chk(A_MASK, 32'h3, "R8 mask set ORs");
        wr(A_MCLR, 32'h3);
        rd_chk(A_MASK, 32'h0, "R8 mask clear");
        chk(irq == 1'b0, "R8 irq low with empty mask", 64'(irq), 64'd0);
        wr(A_MSET, 32'h8);
        chk(irq == 1'b1, "R8 irq from transmit empty", 64'(irq), 64'd1);
        wr(A_MCLR, 32'h8);

        // R10 no transfer with zero count while enabled
        rx_valid = 1'b1; rx_data = 32'hDEAD_BEEF;
        @(negedge clk);
        chk(!rx_ready && !mw_req, "R10 zero count blocks receive", {62'd0, rx_ready, mw_req}, 64'd0);
        @(posedge clk); #1;
        rx_valid = 1'b0;

        // R7 flag clears, R9 hold while disabled
        wr(A_RX_CCNT, 32'd5);
        rd_chk(A_FLAG, 32'hC, "R7 flags clear on nonzero write");
        wr(A_CTRL, 32'h2);
        rx_valid = 1'b1; rx_data = 32'hBAD0_0001;
        repeat (4) begin
            @(negedge clk);
            chk(!rx_ready && !mw_req, "R9 disabled receive idle", {62'd0, rx_ready, mw_req}, 64'd0);
        end
        @(posedge clk); #1;
        rx_valid = 1'b0;
        rd_chk(A_RX_CCNT, 32'd5, "R9 count held");
        rd_chk(A_RX_CPTR, 32'h2008, "R9 pointer held");
        wr(A_CTRL, 32'h1);
        send_rx(32'h2008, 32'h600D_0001);
        idle(1);
        rd_chk(A_RX_CCNT, 32'd4, "R9 resumed count");
        rd_chk(A_RX_CPTR, 32'h200C, "R9 resumed pointer");

        // R6 queued write while current count is zero
        wr(A_RX_CCNT, 32'd0);
        wr(A_RX_NPTR, 32'h3000);
        wr(A_RX_NCNT, 32'd7);
        rd_chk(A_RX_NCNT, 32'd7, "R6 queued count before reload");
        rd_chk(A_RX_CCNT, 32'd0, "R6 current zero before reload");
        @(posedge clk); #1;
        rd_chk(A_RX_CCNT, 32'd7, "R6 reload count");
        rd_chk(A_RX_CPTR, 32'h3000, "R6 reload pointer");
        rd_chk(A_RX_NCNT, 32'd0, "R6 queued count reads zero");
        wr(A_CTRL, 32'h2);

        // R5 / R6 chained transmit with stalls
        wr(A_TX_CPTR, 32'h4000);
        wr(A_TX_CCNT, 32'd2);
        wr(A_TX_NPTR, 32'h5000);
        wr(A_TX_NCNT, 32'd1);
        exp_tx.push_back(mem_word(32'h4000));
        exp_tx.push_back(mem_word(32'h4004));
        exp_tx.push_back(mem_word(32'h5000));
        stall_pat = 1'b1;
        wr(A_CTRL, 32'h4);
        for (int n = 0; n < 400 && exp_tx.size() != 0; n++) @(posedge clk);
        idle(3);
        stall_pat = 1'b0;
        rd_chk(A_TX_CPTR, 32'h5004, "R5 transmit pointer after chain");
        rd_chk(A_TX_CCNT, 32'd0, "R5 transmit count drained");
        rd_chk(A_FLAG, 32'hC, "R7 transmit end and empty set");
        chk(!tx_valid && !mr_req, "R10 transmit idle when empty", {62'd0, tx_valid, mr_req}, 64'd0);

        chk(exp_mw.size() == 0, "R4 all receive words seen", 64'(exp_mw.size()), 64'd0);
        chk(exp_tx.size() == 0, "R5 all transmit words seen", 64'(exp_tx.size()), 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule